// File: doc/BRIEF.md
# Sector Write Protection Gate

This block sits between a memory bus interface and a page write controller and decides, write by write, whether a data byte may reach an 8 KB nonvolatile array. A write gets through only when three conditions hold together. A software unlock command of three fixed writes must have been issued for the current page-load window. The 1 KB sector that the address falls in must not be locked in the protect mask. The external write-control input must be high.

A second command, with the same two-write prefix and a different third byte, arms a load of the protect mask. The next write then supplies the new 8-bit mask in its data byte. A refused write to a locked sector sets a sticky violation flag, and software clears that flag. The permit, together with the address and data it applies to, leaves the block registered one clock after the write strobe. The mask and the violation flag are read back as status.

Top module: `sector_wgate`

## Requirements
- R1: After reset `wr_permit` is 0, `prot_mask` is 8'h00, `viol_flag` is 0, and the command matcher is idle, so no write is permitted.
- R2: With no unlock command issued, a write to any address gives `wr_permit` = 0 in the cycle after the strobe.
- R3: The writes 8'hAA to 13'h1555, 8'h55 to 13'h0AAA and 8'hA0 to 13'h1555, in that order, unlock the gate. Each later write to an unlocked sector gives `wr_permit` = 1 one cycle after its strobe, with `wr_addr_q` and `wr_data_q` equal to that write's address and data.
- R4: A write that does not match the expected step of the command, by address or by data, returns the matcher to idle. The rest of the command written after it does not unlock.
- R5: A one-cycle `page_done` pulse ends the unlock. Writes after it are refused until a new unlock command is issued.
- R6: The writes 8'hAA to 13'h1555, 8'h55 to 13'h0AAA and 8'h80 to 13'h1555 arm a mask load. The data byte of the next write, at any address, becomes `prot_mask`. Bit n locks sector n, where the sector number is address bits [12:10]. The mask does not change at any other time.
- R7: An unlocked write to a locked sector is refused and sets `viol_flag`. The flag stays set until a `viol_clr` pulse clears it. A violation in the same cycle as `viol_clr` leaves the flag set.
- R8: With `prot_mask` = 8'hFF, every write is refused, in whichever sector it falls.
- R9: While `wr_ctl_en` is 0, unlocked writes are refused without setting `viol_flag`, and an armed mask load leaves `prot_mask` unchanged.
- R10: The command writes themselves never produce `wr_permit` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe of a decoded bus write |
| wr_addr | input | 13 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| wr_ctl_en | input | 1 | External write-control, high allows writes |
| page_done | input | 1 | Pulse marking the end of the page-load window |
| viol_clr | input | 1 | Pulse that clears the violation flag |
| wr_permit | output | 1 | Registered permit for the write strobed a cycle earlier |
| wr_addr_q | output | 13 | Address that goes with the permit |
| wr_data_q | output | 8 | Data that goes with the permit |
| prot_mask | output | 8 | Current sector lock mask |
| viol_flag | output | 1 | Sticky locked-sector violation flag |

## Verification
The hardest case to reach is the point where several gates apply at once. A write can be unlocked but land in a locked sector while a clear pulse arrives in the same cycle. A mask load can be armed while the write-control input is low. To get there, the bench first programs a mask through the load command. It then issues a fresh unlock, lowers or raises write-control, and drives the violating write together with `viol_clr` on one edge. It then reads the flag and mask at the ports. Broken sequences, one with a wrong data byte and one with a wrong address, check that a partial command never carries over into a later unlock.

// File: rtl/wgate_pkg.sv
package wgate_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_STEP1 = 3'd1,
    SQ_STEP2 = 3'd2,
    SQ_OPEN  = 3'd3,
    SQ_LOAD  = 3'd4
  } seq_state_t;

  localparam int unsigned MEM_ADDR_W = 13;
  localparam int unsigned MEM_DATA_W = 8;
  localparam int unsigned SECTORS    = 8;

  localparam logic [MEM_ADDR_W-1:0] KEY_ADDR_A = 13'h1555;
  localparam logic [MEM_ADDR_W-1:0] KEY_ADDR_B = 13'h0AAA;
  localparam logic [MEM_DATA_W-1:0] KEY_BYTE_1 = 8'hAA;
  localparam logic [MEM_DATA_W-1:0] KEY_BYTE_2 = 8'h55;
  localparam logic [MEM_DATA_W-1:0] KEY_OPEN   = 8'hA0;
  localparam logic [MEM_DATA_W-1:0] KEY_MASK   = 8'h80;

endpackage

// File: rtl/wgate_seq.sv
module wgate_seq
  import wgate_pkg::*;
#(
  parameter int unsigned ADDR_W = MEM_ADDR_W,
  parameter int unsigned DATA_W = MEM_DATA_W,
  parameter logic [ADDR_W-1:0] ADDR_A = KEY_ADDR_A,
  parameter logic [ADDR_W-1:0] ADDR_B = KEY_ADDR_B,
  parameter logic [DATA_W-1:0] BYTE_1 = KEY_BYTE_1,
  parameter logic [DATA_W-1:0] BYTE_2 = KEY_BYTE_2,
  parameter logic [DATA_W-1:0] BYTE_OPEN = KEY_OPEN,
  parameter logic [DATA_W-1:0] BYTE_MASK = KEY_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              page_end,
  output logic              is_open,
  output logic              is_load
);

  seq_state_t state_q, state_d;

  logic hit_step1, hit_step2, hit_open, hit_mask;

  // Per-step match of the incoming write against the command keys.
  always_comb begin
    hit_step1 = (addr == ADDR_A) && (data == BYTE_1);
    hit_step2 = (addr == ADDR_B) && (data == BYTE_2);
    hit_open  = (addr == ADDR_A) && (data == BYTE_OPEN);
    hit_mask  = (addr == ADDR_A) && (data == BYTE_MASK);
  end

  always_comb begin
    state_d = state_q;
    if (stb) begin
      unique case (state_q)
        SQ_IDLE:  state_d = hit_step1 ? SQ_STEP1 : SQ_IDLE;
        SQ_STEP1: state_d = hit_step2 ? SQ_STEP2 : SQ_IDLE;
        SQ_STEP2: begin
          if (hit_open)      state_d = SQ_OPEN;
          else if (hit_mask) state_d = SQ_LOAD;
          else               state_d = SQ_IDLE;
        end
        SQ_OPEN:  state_d = SQ_OPEN;
        SQ_LOAD:  state_d = SQ_IDLE;
        default:  state_d = SQ_IDLE;
      endcase
    end
    // The end of the page window always closes the gate.
    if (page_end) state_d = SQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SQ_IDLE;
    else     state_q <= state_d;
  end

  assign is_open = (state_q == SQ_OPEN);
  assign is_load = (state_q == SQ_LOAD);

  // R5: a page-end pulse always leaves the gate closed afterwards.
  p_page_end_closes_r5: assert property (@(posedge clk) disable iff (rst)
    $past(page_end) |-> !is_open);

  // R6: a load is armed only right after a matching third command write.
  p_load_after_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(is_load) |-> $past(stb));

  p_states_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_open, is_load}));

endmodule

// File: rtl/wgate_lock_bank.sv
module wgate_lock_bank
  import wgate_pkg::*;
#(
  parameter int unsigned ADDR_W = MEM_ADDR_W,
  parameter int unsigned N_SECT = SECTORS,
  localparam int unsigned SECT_BITS = (N_SECT > 1) ? $clog2(N_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load_en,
  input  logic [N_SECT-1:0] load_val,
  input  logic              viol_set,
  input  logic              viol_clr,
  output logic              locked,
  output logic [N_SECT-1:0] mask,
  output logic              viol
);

  logic [SECT_BITS-1:0] sect_idx;
  logic [N_SECT-1:0]    sect_hit;

  // Upper address bits select the sector.
  assign sect_idx = addr[ADDR_W-1 -: SECT_BITS];

  for (genvar gi = 0; gi < N_SECT; gi++) begin : g_sect
    assign sect_hit[gi] = (sect_idx == SECT_BITS'(gi));
  end

  assign locked = |(sect_hit & mask);

  always_ff @(posedge clk) begin
    if (rst)          mask <= '0;
    else if (load_en) mask <= load_val;
  end

  // A new violation takes priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)           viol <= 1'b0;
    else if (viol_set) viol <= 1'b1;
    else if (viol_clr) viol <= 1'b0;
  end

  // R6: the mask moves only on an accepted load.
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(load_en) |-> $stable(mask));

  // R7: the violation flag is sticky until cleared.
  p_viol_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(viol) && !$past(viol_clr)) |-> viol);

  p_viol_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(viol) |-> $past(viol_set));

endmodule

// File: rtl/sector_wgate.sv
module sector_wgate
  import wgate_pkg::*;
#(
  parameter int unsigned ADDR_W = MEM_ADDR_W,
  parameter int unsigned DATA_W = MEM_DATA_W,
  parameter int unsigned N_SECT = SECTORS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ctl_en,
  input  logic              page_done,
  input  logic              viol_clr,
  output logic              wr_permit,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic [DATA_W-1:0] wr_data_q,
  output logic [N_SECT-1:0] prot_mask,
  output logic              viol_flag
);

  logic gate_open, load_armed, sect_locked;
  logic grant, refuse_lock, mask_load;

  wgate_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .stb      (wr_stb),
    .addr     (wr_addr),
    .data     (wr_data),
    .page_end (page_done),
    .is_open  (gate_open),
    .is_load  (load_armed)
  );

  always_comb begin
    grant       = wr_stb && gate_open && wr_ctl_en && !sect_locked;
    refuse_lock = wr_stb && gate_open && wr_ctl_en &&  sect_locked;
    mask_load   = wr_stb && load_armed && wr_ctl_en;
  end

  wgate_lock_bank #(
    .ADDR_W (ADDR_W),
    .N_SECT (N_SECT)
  ) u_lock (
    .clk      (clk),
    .rst      (rst),
    .addr     (wr_addr),
    .load_en  (mask_load),
    .load_val (wr_data[N_SECT-1:0]),
    .viol_set (refuse_lock),
    .viol_clr (viol_clr),
    .locked   (sect_locked),
    .mask     (prot_mask),
    .viol     (viol_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_permit <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_permit <= grant;
      if (wr_stb) begin
        wr_addr_q <= wr_addr;
        wr_data_q <= wr_data;
      end
    end
  end

  // R3, R10: a permit follows only a strobe while the gate was open.
  p_permit_open_r3: assert property (@(posedge clk) disable iff (rst)
    wr_permit |-> $past(gate_open && wr_stb));

  // R8: a permitted write never fell in a locked sector.
  p_permit_unlocked_r8: assert property (@(posedge clk) disable iff (rst)
    wr_permit |-> !$past(sect_locked));

  // R9: write-control low blocks every permit.
  p_permit_ctl_r9: assert property (@(posedge clk) disable iff (rst)
    wr_permit |-> $past(wr_ctl_en));

endmodule

// File: tb/sector_wgate_bench.sv
module sector_wgate_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_stb;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_ctl_en;
  logic        page_done;
  logic        viol_clr;
  logic        wr_permit;
  logic [12:0] wr_addr_q;
  logic [7:0]  wr_data_q;
  logic [7:0]  prot_mask;
  logic        viol_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  sector_wgate u_sector_wgate (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_ctl_en (wr_ctl_en),
    .page_done (page_done),
    .viol_clr  (viol_clr),
    .wr_permit (wr_permit),
    .wr_addr_q (wr_addr_q),
    .wr_data_q (wr_data_q),
    .prot_mask (prot_mask),
    .viol_flag (viol_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobed write; returns the permit seen one cycle later.
  task automatic wr(input logic [12:0] a, input logic [7:0] d, output logic p);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    p = wr_permit;
  endtask

  task automatic unlock(output logic p3);
    logic p1, p2, p0;
    wr(13'h1555, 8'hAA, p1);
    wr(13'h0AAA, 8'h55, p2);
    wr(13'h1555, 8'hA0, p0);
    p3 = p1 | p2 | p0;
  endtask

  task automatic load_mask(input logic [7:0] m, input logic [12:0] a);
    logic p;
    wr(13'h1555, 8'hAA, p);
    wr(13'h0AAA, 8'h55, p);
    wr(13'h1555, 8'h80, p);
    wr(a, m, p);
  endtask

  task automatic end_page();
    @(negedge clk); page_done = 1'b1;
    @(negedge clk); page_done = 1'b0;
  endtask

  task automatic clear_viol();
    @(negedge clk); viol_clr = 1'b1;
    @(negedge clk); viol_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 permit", {31'd0, wr_permit}, 32'd0);
    chk("R1 mask", {24'd0, prot_mask}, 32'h00);
    chk("R1 viol", {31'd0, viol_flag}, 32'd0);
  endtask

  task automatic t_no_unlock();
    logic p;
    wr(13'h0100, 8'h11, p);
    chk("R2 write without unlock", {31'd0, p}, 32'd0);
    wr(13'h1FFF, 8'h22, p);
    chk("R2 top address without unlock", {31'd0, p}, 32'd0);
  endtask

  task automatic t_unlock();
    logic p, pc;
    unlock(pc);
    chk("R10 command writes not permitted", {31'd0, pc}, 32'd0);
    wr(13'h0123, 8'h5A, p);
    chk("R3 permit after unlock", {31'd0, p}, 32'd1);
    chk("R3 address out", {19'd0, wr_addr_q}, 32'h0123);
    chk("R3 data out", {24'd0, wr_data_q}, 32'h5A);
    wr(13'h0124, 8'hC3, p);
    chk("R3 second byte in page", {31'd0, p}, 32'd1);
    chk("R3 second data out", {24'd0, wr_data_q}, 32'hC3);
    end_page();
    wr(13'h0125, 8'h01, p);
    chk("R5 refused after page end", {31'd0, p}, 32'd0);
  endtask

  task automatic t_mismatch();
    logic p;
    wr(13'h1555, 8'hAA, p);
    wr(13'h0AAA, 8'h56, p);
    wr(13'h1555, 8'hA0, p);
    wr(13'h0200, 8'h33, p);
    chk("R4 wrong data byte", {31'd0, p}, 32'd0);
    wr(13'h1555, 8'hAA, p);
    wr(13'h0AAB, 8'h55, p);
    wr(13'h1555, 8'hA0, p);
    wr(13'h0200, 8'h33, p);
    chk("R4 wrong address", {31'd0, p}, 32'd0);
  endtask

  task automatic t_mask();
    logic p, pc;
    load_mask(8'h24, 13'h0777);
    chk("R6 mask loaded", {24'd0, prot_mask}, 32'h24);
    unlock(pc);
    wr(13'h0800, 8'h44, p);
    chk("R7 locked sector 2 refused", {31'd0, p}, 32'd0);
    chk("R7 violation set", {31'd0, viol_flag}, 32'd1);
    wr(13'h0C00, 8'h45, p);
    chk("R7 sector 3 permitted", {31'd0, p}, 32'd1);
    chk("R7 violation sticky", {31'd0, viol_flag}, 32'd1);
    wr(13'h17FF, 8'h46, p);
    chk("R7 locked sector 5 refused", {31'd0, p}, 32'd0);
    clear_viol();
    chk("R7 violation cleared", {31'd0, viol_flag}, 32'd0);
    // Violation and clear on the same edge: the set wins.
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = 13'h0A00; wr_data = 8'h47; viol_clr = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; viol_clr = 1'b0;
    chk("R7 set beats clear", {31'd0, viol_flag}, 32'd1);
    chk("R6 mask unchanged by data writes", {24'd0, prot_mask}, 32'h24);
    end_page();
    clear_viol();
  endtask

  task automatic t_all_locked();
    logic p, pc;
    load_mask(8'hFF, 13'h0000);
    chk("R8 mask all ones", {24'd0, prot_mask}, 32'hFF);
    unlock(pc);
    wr(13'h0000, 8'h10, p);
    chk("R8 sector 0 refused", {31'd0, p}, 32'd0);
    wr(13'h1C10, 8'h11, p);
    chk("R8 sector 7 refused", {31'd0, p}, 32'd0);
    end_page();
    clear_viol();
    load_mask(8'h00, 13'h1234);
    chk("R6 mask cleared", {24'd0, prot_mask}, 32'h00);
  endtask

  task automatic t_wc();
    logic p, pc;
    wr_ctl_en = 1'b0;
    unlock(pc);
    wr(13'h0300, 8'h99, p);
    chk("R9 write control low refuses", {31'd0, p}, 32'd0);
    chk("R9 no violation", {31'd0, viol_flag}, 32'd0);
    end_page();
    load_mask(8'h0F, 13'h0000);
    chk("R9 mask load ignored", {24'd0, prot_mask}, 32'h00);
    wr_ctl_en = 1'b1;
    unlock(pc);
    wr(13'h0300, 8'h9A, p);
    chk("R9 write control high permits", {31'd0, p}, 32'd1);
    end_page();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
    wr_ctl_en = 1'b1; page_done = 1'b0; viol_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_no_unlock();
    t_unlock();
    t_mismatch();
    t_mask();
    t_all_locked();
    t_wc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule